// File: doc/BRIEF.md
# Masked Interrupt Flag Aggregator

This block sits between the event outputs of a multi-channel timer and the interrupt controller. Each channel raises a one-cycle event pulse. The block captures each pulse in a sticky flag bit and keeps a separate mask bit for each source. It then drives a small set of level-sensitive parent interrupt lines. Each line is the OR of the unmasked flags in its own group of sources.

Software works through a simple register port. Write-only addresses let it acknowledge flags and set or clear mask bits one bit at a time, with write-one semantics. Bits written as zero leave the state alone. Read addresses return the raw flags, the mask and the pending view.

How sources are grouped onto parent lines is set by a parameter. The default gives channel 0 and channel 1 a line each and puts channels 2 to 7 on a third, shared line. A single-bit mask for one channel on one line, with the others on a second line, is equally possible. The expected use is to acknowledge a flag first and unmask it afterwards.

Top module: `irq_flag_agg`

## Requirements
- R1: After reset, every flag bit is 0, every mask bit is 1 (all sources masked) and every parent line is low.
- R2: A one-cycle high on `evt_i[b]` sets flag bit b at the next clock edge, whether or not b is masked. The flag then stays set until it is acknowledged.
- R3: A write to address 2 (flag clear) clears each flag bit whose data bit is 1. Flag bits whose data bit is 0 are unchanged.
- R4: When an event on bit b and a flag-clear write with data bit b land in the same cycle, flag bit b is 1 afterwards. Other bits in that clear write are still cleared.
- R5: A write to address 4 (mask set) sets each mask bit whose data bit is 1. Mask bits whose data bit is 0 are unchanged.
- R6: A write to address 5 (mask clear) clears each mask bit whose data bit is 1. Mask bits whose data bit is 0 are unchanged.
- R7: Address 6 reads the pending view: the flag bits ANDed with the inverted mask bits.
- R8: Parent line k is high exactly while some pending bit in group k is set. Group k is the k-th `NSRC`-bit slice of `LINE_MAP`. By default, line 0 carries channel 0, line 1 carries channel 1, line 2 carries channels 2 to 7, and channels 8 to 31 reach no line.
- R9: A write to address 1 (flag set, for test) sets each flag bit whose data bit is 1.
- R10: Address 0 reads the flags and address 3 reads the mask. Any other read address returns 0. Writes to the read-only addresses 0, 3 and 6 change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| evt_i | input | NSRC | Event pulses from the timer channels |
| we_i | input | 1 | Register write strobe |
| waddr_i | input | AW | Write address |
| wdata_i | input | NSRC | Write data, one bit per source |
| raddr_i | input | AW | Read address |
| rdata_o | output | NSRC | Read data, combinational from raddr_i |
| irq_o | output | NLINES | Level-sensitive parent interrupt lines |

## Verification
Events are pulsed on masked sources, on unmasked sources and on sources outside every group. These cases separate latching from masking and from routing. Acknowledges are written with single-bit and multi-bit patterns, and one acknowledge collides with an event in the same cycle. This shows the set-over-clear priority and confirms that neighbouring bits are untouched. One source is raised at a time on each default group, and a flagged source is masked afterwards. Together these tell apart a wrong group slice, a missing mask term and an edge-triggered line where a level is required.

// File: rtl/irq_flag_agg.sv
module irq_flag_agg #(
  parameter int NSRC   = 32,
  parameter int NLINES = 3,
  parameter int AW     = 3,
  parameter logic [NLINES*NSRC-1:0] LINE_MAP = {32'h0000_00FC, 32'h0000_0002, 32'h0000_0001}
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NSRC-1:0]   evt_i,
  input  logic              we_i,
  input  logic [AW-1:0]     waddr_i,
  input  logic [NSRC-1:0]   wdata_i,
  input  logic [AW-1:0]     raddr_i,
  output logic [NSRC-1:0]   rdata_o,
  output logic [NLINES-1:0] irq_o
);
  localparam logic [AW-1:0] A_FLAG  = AW'(0);
  localparam logic [AW-1:0] A_FSET  = AW'(1);
  localparam logic [AW-1:0] A_FCLR  = AW'(2);
  localparam logic [AW-1:0] A_MASK  = AW'(3);
  localparam logic [AW-1:0] A_MSET  = AW'(4);
  localparam logic [AW-1:0] A_MCLR  = AW'(5);
  localparam logic [AW-1:0] A_PEND  = AW'(6);
  localparam logic [NSRC-1:0] ZERO  = '0;

  logic [NSRC-1:0] flag_q, mask_q, pend;
  logic [NSRC-1:0] fset_v, fclr_v, mset_v, mclr_v;

  assign fset_v = (we_i && waddr_i == A_FSET) ? wdata_i : ZERO;
  assign fclr_v = (we_i && waddr_i == A_FCLR) ? wdata_i : ZERO;
  assign mset_v = (we_i && waddr_i == A_MSET) ? wdata_i : ZERO;
  assign mclr_v = (we_i && waddr_i == A_MCLR) ? wdata_i : ZERO;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      flag_q <= '0;
      mask_q <= '1;
    end else begin
      flag_q <= (flag_q & ~fclr_v) | evt_i | fset_v;
      mask_q <= (mask_q & ~mclr_v) | mset_v;
    end
  end

  assign pend = flag_q & ~mask_q;

  for (genvar k = 0; k < NLINES; k++) begin : g_line
    assign irq_o[k] = |(pend & LINE_MAP[k*NSRC +: NSRC]);
  end

  always_comb begin
    case (raddr_i)
      A_FLAG:  rdata_o = flag_q;
      A_MASK:  rdata_o = mask_q;
      A_PEND:  rdata_o = pend;
      default: rdata_o = ZERO;
    endcase
  end

  // R2 R4
  evt_latched_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_i != ZERO) |=> ((flag_q & $past(evt_i)) == $past(evt_i)));

  // R3
  ack_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && waddr_i == A_FCLR && evt_i == ZERO) |=> ((flag_q & $past(wdata_i)) == ZERO));

  // R5
  mask_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && waddr_i == A_MSET) |=> ((mask_q & $past(wdata_i)) == $past(wdata_i)));

  // R6
  mask_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && waddr_i == A_MCLR) |=> ((mask_q & $past(wdata_i)) == ZERO));

  // R10
  mask_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(we_i && (waddr_i == A_MSET || waddr_i == A_MCLR)) |=> $stable(mask_q));

  // R8
  all_masked_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mask_q == '1) |-> (irq_o == '0));
endmodule

// File: tb/irq_flag_agg_tb.sv
module irq_flag_agg_tb;
  localparam int N = 32;
  logic clk = 0, rst_n = 0;
  logic [N-1:0] evt = '0, wdata = '0;
  logic we = 0;
  logic [2:0] waddr = '0, raddr = '0;
  logic [N-1:0] rdata;
  logic [2:0] irq;
  int total = 0, fails = 0;

  always #10 clk = ~clk;

  irq_flag_agg u_dut (.clk_i(clk), .rst_ni(rst_n), .evt_i(evt), .we_i(we),
    .waddr_i(waddr), .wdata_i(wdata), .raddr_i(raddr), .rdata_o(rdata), .irq_o(irq));

  task automatic check(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [N-1:0] d);
    @(negedge clk); we = 1; waddr = a; wdata = d;
    @(negedge clk); we = 0; wdata = '0;
  endtask

  task automatic pulse(input logic [N-1:0] v);
    @(negedge clk); evt = v;
    @(negedge clk); evt = '0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [N-1:0] d);
    raddr = a; #1; d = rdata;
  endtask

  task automatic expect_reg(input string req, input logic [2:0] a, input logic [N-1:0] exp);
    logic [N-1:0] d;
    rd(a, d); check(req, d, exp);
  endtask

  task automatic clean();
    wr(3'd4, '1); wr(3'd2, '1);
  endtask

  task automatic t_reset();
    expect_reg("R1 flag", 3'd0, '0);
    expect_reg("R1 mask", 3'd3, '1);
    check("R1 irq", {29'd0, irq}, '0);
  endtask

  task automatic t_masked_event();
    pulse(32'h0000_0010);
    expect_reg("R2 masked flag", 3'd0, 32'h10);
    expect_reg("R7 masked pend", 3'd6, '0);
    check("R8 masked irq", {29'd0, irq}, '0);
    repeat (3) @(negedge clk);
    expect_reg("R2 sticky", 3'd0, 32'h10);
    wr(3'd5, 32'h10);
    expect_reg("R7 unmasked pend", 3'd6, 32'h10);
    check("R8 shared line", {29'd0, irq}, 32'h4);
    clean();
  endtask

  task automatic t_ack();
    wr(3'd1, 32'hA5A5_0F0F);
    expect_reg("R9 test set", 3'd0, 32'hA5A5_0F0F);
    wr(3'd2, 32'h0000_0F00);
    expect_reg("R3 partial ack", 3'd0, 32'hA5A5_000F);
    wr(3'd2, 32'h8000_0001);
    expect_reg("R3 second ack", 3'd0, 32'h25A5_000E);
    clean();
    expect_reg("R3 full ack", 3'd0, '0);
  endtask

  task automatic t_set_wins();
    wr(3'd1, 32'h0000_00C0);
    @(negedge clk); evt = 32'h8; we = 1; waddr = 3'd2; wdata = 32'h0000_00C8;
    @(negedge clk); evt = '0; we = 0; wdata = '0;
    expect_reg("R4 set wins", 3'd0, 32'h8);
    clean();
  endtask

  task automatic t_mask_ops();
    wr(3'd5, 32'h0000_FFFF);
    expect_reg("R6 mask clear", 3'd3, 32'hFFFF_0000);
    wr(3'd4, 32'h0000_0300);
    expect_reg("R5 mask set", 3'd3, 32'hFFFF_0300);
    wr(3'd0, '0); wr(3'd3, '1); wr(3'd6, '1);
    expect_reg("R10 ro mask", 3'd3, 32'hFFFF_0300);
    expect_reg("R10 ro flag", 3'd0, '0);
    expect_reg("R10 unused addr", 3'd7, '0);
    wr(3'd1, 32'h0001_0101);
    expect_reg("R7 pending", 3'd6, 32'h0000_0001);
    clean();
  endtask

  task automatic t_groups();
    wr(3'd5, '1);
    pulse(32'h1);
    check("R8 line0", {29'd0, irq}, 32'h1);
    wr(3'd2, 32'h1);
    check("R8 line0 ack", {29'd0, irq}, 32'h0);
    pulse(32'h2);
    check("R8 line1", {29'd0, irq}, 32'h2);
    wr(3'd2, 32'h2);
    pulse(32'h20);
    check("R8 line2", {29'd0, irq}, 32'h4);
    wr(3'd4, 32'h20);
    check("R8 masked drops", {29'd0, irq}, 32'h0);
    pulse(32'h0010_0000);
    check("R8 ungrouped", {29'd0, irq}, 32'h0);
    expect_reg("R7 ungrouped pend", 3'd6, 32'h0010_0000);
    clean();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_masked_event();
    t_ack();
    t_set_wins();
    t_mask_ops();
    t_groups();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    #200us;
    total++; fails++;
    $display("FAIL watchdog actual=expired expected=done");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule